// File: doc/BRIEF.md
# SPI Serial Clock Divider with Two Ratio Modes

This block produces the serial clock for an SPI shift engine from the module clock. A single configuration word, written through one write port, carries two divider fields and a select bit. The select bit picks a linear ratio or a power-of-two ratio. The linear ratio is an even divide of 2 to 512. The power-of-two ratio divides by 2 up to 65536. The output clock has a 50% duty cycle. While disabled, the output rests at the level set by the clock-polarity input.

Alongside the serial clock the block gives two strobes for the shift engine. Each strobe is high for one module-clock cycle. The leading strobe marks the edge that moves the clock away from idle. The trailing strobe marks the edge that returns it to idle. A new divider setting is picked up only at a half-period boundary, so the output never shows a shortened pulse.

This block has no streaming data path. Every pin is a plain control or status signal, and there is no back-pressure.

Top module: `spi_sclk_divider`

## Requirements
- R1: During and directly after reset, `sclk` equals `cpol` and both strobes are low. The stored configuration resets to zero.
- R2: While `en` is low, `sclk` equals `cpol` and no strobe is raised. Configuration writes made in this state produce no edge.
- R3: When configuration bit 12 is 1, each half period lasts n+1 module cycles, where n is configuration bits 7:0.
- R4: When configuration bit 12 is 0, each half period lasts 2^n module cycles, where n is configuration bits 11:8.
- R5: With a half period of H cycles, the first `sclk` transition happens at the H-th rising clock edge at which `en` is sampled high.
- R6: `lead_stb` is high for exactly the one cycle in which `sclk` has just left its idle level. `trail_stb` is high for exactly the one cycle in which `sclk` has just returned to idle.
- R7: With `cpol` = 1, the idle level is high and the waveform is the inverse of the `cpol` = 0 waveform, with the same strobe timing.
- R8: A configuration write while running leaves the current half period at its old length. The new length applies from the next half-period boundary.
- R9: The two strobes are never high together, and `sclk` changes while enabled only together with a strobe.
- R10: Dropping `en` returns `sclk` to idle on the next clock edge and clears the count. A later enable again waits one full half period before the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable for the serial clock |
| cpol | input | 1 | Idle level of the serial clock |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 13 | Configuration word: bits 7:0 linear n, bits 11:8 exponent n, bit 12 mode select (1 = linear) |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe on the edge leaving idle |
| trail_stb | output | 1 | One-cycle strobe on the edge returning to idle |

## Verification
A configuration write is stored at the next clock edge. While disabled, the active half length reloads one edge after that. The bench therefore waits two cycles after a write before it raises `en`. After `en` is raised, the j-th rising edge produces sample j. Transitions and strobes fall on the samples where j is a multiple of H. The bench computes the expected level and strobes for each sample arithmetically from j and H, and it samples on the falling edge so that every register has settled. For a write made mid-run, the bench expects the old length until the next boundary, because the write lands one edge later and the new length loads at that boundary.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
  typedef enum logic {
    DIV_POW2   = 1'b0,
    DIV_LINEAR = 1'b1
  } div_mode_e;

  function automatic int unsigned cnt_width(input int unsigned lin_w, input int unsigned exp_w);
    int unsigned pw;
    pw = (1 << exp_w) - 1;
    return (lin_w > pw) ? lin_w : pw;
  endfunction
endpackage

// File: rtl/sclk_cfg_reg.sv
module sclk_cfg_reg #(
  parameter int unsigned CFG_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg <= '0;
    else if (we) cfg <= wdata;
  end
endmodule

// File: rtl/sclk_half_decode.sv
module sclk_half_decode
  import sclk_div_pkg::*;
#(
  parameter int unsigned LIN_W = 8,
  parameter int unsigned EXP_W = 4,
  parameter int unsigned CNT_W = 15,
  localparam int unsigned CFG_W = LIN_W + EXP_W + 1
) (
  input  logic [CFG_W-1:0] cfg,
  output logic [CNT_W-1:0] half_last
);
  logic [LIN_W-1:0] lin_n;
  logic [EXP_W-1:0] exp_n;
  div_mode_e        mode;
  logic [CNT_W-1:0] lin_last;
  logic [CNT_W-1:0] pow_last;

  assign lin_n = cfg[LIN_W-1:0];
  assign exp_n = cfg[LIN_W+EXP_W-1:LIN_W];
  assign mode  = div_mode_e'(cfg[CFG_W-1]);

  // linear: n+1 cycles per half, stored as n
  assign lin_last = CNT_W'(lin_n);
  // power of two: 2^n cycles per half, stored as 2^n - 1
  assign pow_last = (CNT_W'(1) << exp_n) - CNT_W'(1);

  always_comb begin
    if (mode == DIV_LINEAR) half_last = lin_last;
    else                    half_last = pow_last;
  end
endmodule

// File: rtl/sclk_edge_gen.sv
module sclk_edge_gen #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] next_last,
  output logic             phase,
  output logic             lead_stb,
  output logic             trail_stb
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cur_last;
  logic             wrap;

  assign wrap = (cnt == cur_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      cur_last  <= '0;
      phase     <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else if (!en) begin
      cnt       <= '0;
      cur_last  <= next_last;
      phase     <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else if (wrap) begin
      cnt       <= '0;
      cur_last  <= next_last;
      phase     <= ~phase;
      lead_stb  <= ~phase;
      trail_stb <= phase;
    end else begin
      cnt       <= cnt + CNT_W'(1);
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider
  import sclk_div_pkg::*;
#(
  parameter int unsigned LIN_W = 8,
  parameter int unsigned EXP_W = 4,
  localparam int unsigned CFG_W = LIN_W + EXP_W + 1,
  localparam int unsigned CNT_W = cnt_width(LIN_W, EXP_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cpol,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb
);
  logic [CFG_W-1:0] cfg;
  logic [CNT_W-1:0] half_last;
  logic             phase;

  sclk_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg)
  );

  sclk_half_decode #(.LIN_W(LIN_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_dec (
    .cfg(cfg), .half_last(half_last)
  );

  sclk_edge_gen #(.CNT_W(CNT_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .next_last(half_last),
    .phase(phase), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  assign sclk = phase ^ cpol;
endmodule

// File: rtl/sclk_div_checker.sv
module sclk_div_checker (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic cpol,
  input logic sclk,
  input logic lead_stb,
  input logic trail_stb
);
  assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sclk == cpol));

  assert_strobe_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb));

  assert_lead_leaves_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |-> (sclk != cpol));

  assert_trail_at_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |-> (sclk == cpol));

  assert_strobe_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_stb || trail_stb) |-> $past(en));

  assert_edge_has_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(cpol) && $past(en) && !$stable(sclk)) |-> (lead_stb || trail_stb));
endmodule

bind spi_sclk_divider sclk_div_checker u_sclk_div_checker (
  .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol),
  .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
);

// File: tb/tb_spi_sclk_divider.sv
module tb_spi_sclk_divider;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        cpol = 1'b0;
  logic        cfg_we = 1'b0;
  logic [12:0] cfg_wdata = '0;
  logic        sclk, lead_stb, trail_stb;

  int vectors = 0;
  int miscompares = 0;

  spi_sclk_divider dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: {sclk,lead,trail} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] model(input int j, input int h, input logic pol);
    int t;
    int r;
    t = j / h;
    r = j % h;
    return {pol ^ logic'(t % 2),
            (r == 0) && (t % 2 == 1),
            (r == 0) && (t > 0) && (t % 2 == 0)};
  endfunction

  task automatic write_cfg(input logic [12:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // mode 1: linear (bit 12 = 1, n in 7:0); mode 0: power of two (n in 11:8)
  task automatic run_cfg(input logic lin, input int n, input logic pol);
    int h;
    string tag;
    logic [2:0] e;
    h   = lin ? n + 1 : (1 << n);
    tag = lin ? "R3" : "R4";
    if (pol) tag = {tag, "/R7"};
    cpol = pol;
    write_cfg(lin ? {1'b1, 4'd0, 8'(n)} : {1'b0, 4'(n), 8'd0});
    @(negedge clk);
    en = 1'b1;
    for (int j = 1; j <= 4 * h; j++) begin
      @(negedge clk);
      e = model(j, h, pol);
      if (j <= h) chk({tag, " R5 first edge"}, {sclk, lead_stb, trail_stb}, e);
      else begin
        chk(tag, {sclk, 1'b0, 1'b0}, {e[2], 1'b0, 1'b0});
        chk("R6 strobes", {1'b0, lead_stb, trail_stb}, {1'b0, e[1:0]});
      end
    end
    en = 1'b0;
    @(negedge clk);
    chk("R2 disabled", {sclk, lead_stb, trail_stb}, {pol, 2'b00});
  endtask

  initial begin
    #(PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [2:0] e;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 reset", {sclk, lead_stb, trail_stb}, 3'b000);
    cpol = 1'b1;
    #1;
    chk("R1 reset cpol", {sclk, lead_stb, trail_stb}, 3'b100);
    cpol = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {sclk, lead_stb, trail_stb}, 3'b000);

    // R2: writes while disabled produce nothing
    write_cfg({1'b1, 4'd0, 8'd0});
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R2 idle after write", {sclk, lead_stb, trail_stb}, 3'b000);
    end

    // R3 linear sweep
    for (int n = 0; n < 32; n++) begin
      run_cfg(1'b1, n, 1'b0);
      run_cfg(1'b1, n, 1'b1);
    end
    run_cfg(1'b1, 255, 1'b0);
    // R4 power-of-two sweep
    for (int n = 0; n <= 12; n++) run_cfg(1'b0, n, 1'b0);
    for (int n = 0; n <= 4; n++)  run_cfg(1'b0, n, 1'b1);

    // R8: change mid-run from H=4 to H=2; edges at 4, 8, 10, 12
    cpol = 1'b0;
    write_cfg({1'b1, 4'd0, 8'd3});
    @(negedge clk);
    en = 1'b1;
    for (int j = 1; j <= 12; j++) begin
      @(negedge clk);
      if (j == 6) begin cfg_we = 1'b1; cfg_wdata = {1'b1, 4'd0, 8'd1}; end
      if (j == 7) cfg_we = 1'b0;
      e = (j < 8) ? model(j, 4, 1'b0) : model(j - 8 + 4, 2, 1'b0);
      chk("R8 update at boundary", {sclk, lead_stb, trail_stb}, e);
    end
    en = 1'b0;
    @(negedge clk);

    // R10: drop en while sclk is high, then restart with full half period
    write_cfg({1'b1, 4'd0, 8'd2});
    @(negedge clk);
    en = 1'b1;
    for (int j = 1; j <= 4; j++) @(negedge clk);
    chk("R10 running high", {sclk, lead_stb, trail_stb}, 3'b100);
    en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 back to idle", {sclk, lead_stb, trail_stb}, 3'b000);
    end
    en = 1'b1;
    for (int j = 1; j <= 9; j++) begin
      @(negedge clk);
      chk("R10 restart", {sclk, lead_stb, trail_stb}, model(j, 3, 1'b0));
    end
    en = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule